// File: doc/BRIEF.md
# Execute-Stage Alignment Checker

This block sits in the execute stage of a 32-bit RISC-V style core and checks two kinds of address in the cycle they are computed. The first is the effective address of a data access, whose alignment rule depends on the access size. The second is the destination of a taken branch or jump, which must fall on a 4-byte boundary. The logic is purely combinational. Its results are seen at the outputs in the same cycle as the inputs.

When an address breaks its rule, the block raises a misalignment flag. It gives a 4-bit exception cause: 0 for a control-transfer target, 4 for a load, 6 for a store. It also returns the offending address as the trap value. In the same cycle it withdraws the outgoing memory request and write-enable, so a faulting access leaves memory untouched. The trap controller downstream uses the flag, cause and value to enter the handler. Emulating the access and sequencing the trap are not part of this block.

An access is described by three inputs. `mem_req_i` = 1 means a load or store is present. `mem_we_i` = 1 means it is a store and 0 means a load. `mem_size_i` gives the size: 00 = byte, 01 = halfword (signed or unsigned), 10 = word, 11 = treated as word.

Top module: `align_checker`

## Requirements
- R1: With `xfer_taken_i`=1 and `xfer_target_i[1:0]` nonzero, `misalign_o`=1, `cause_o`=0 and `tval_o` equals the target.
- R2: With `xfer_taken_i`=0 the target is never checked, whatever its value.
- R3: A word load (req=1, we=0, size=10) with nonzero address bits 1:0 gives `misalign_o`=1 and `cause_o`=4.
- R4: A halfword load (size=01) with address bit 0 set gives `cause_o`=4. Address bit 1 alone does not flag it.
- R5: A word store (req=1, we=1, size=10) with nonzero address bits 1:0 gives `misalign_o`=1 and `cause_o`=6.
- R6: A halfword store (size=01) with address bit 0 set gives `cause_o`=6. Address bit 1 alone does not flag it.
- R7: A byte access (size=00), load or store, is never flagged.
- R8: On a data fault `tval_o` equals `mem_addr_i`. With no fault, `misalign_o`=0, `cause_o`=0 and `tval_o`=0.
- R9: In the same cycle as any fault, `mem_req_o`=0 and `mem_we_o`=0. With no fault, `mem_req_o`=`mem_req_i` and `mem_we_o`=`mem_req_i & mem_we_i`.
- R10: When a target fault and a data fault occur together, the target fault is reported (cause 0, `tval_o` = target) and memory is still suppressed.
- R11: With `mem_req_i`=0 the data address is not checked.
- R12: Size code 11 follows the word rule (address bits 1:0 must be zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_req_i | input | 1 | Data access present this cycle |
| mem_we_i | input | 1 | 1 = store, 0 = load |
| mem_size_i | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 word |
| mem_addr_i | input | XLEN | Effective data address |
| xfer_taken_i | input | 1 | Branch or jump is taken |
| xfer_target_i | input | XLEN | Control-transfer destination |
| misalign_o | output | 1 | Alignment fault detected |
| cause_o | output | 4 | Exception cause code (0, 4 or 6) |
| tval_o | output | XLEN | Offending address, 0 if no fault |
| mem_req_o | output | 1 | Memory request after suppression |
| mem_we_o | output | 1 | Memory write-enable after suppression |

## Verification
Two functions of the block can act in the same cycle: the target check of a taken transfer and the data-address check with its write suppression. The bench provokes both at once by sweeping every combination of access presence, direction, size, low address bits, taken flag and low target bits. This includes cases where a misaligned store meets a misaligned taken target. In each such case it judges that cause 0 and the target win over the store's cause and address, and that the write-enable is still held low.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    localparam logic [3:0] CAUSE_XFER_MIS  = 4'd0;
    localparam logic [3:0] CAUSE_LOAD_MIS  = 4'd4;
    localparam logic [3:0] CAUSE_STORE_MIS = 4'd6;

    typedef struct packed {
        logic       hit;
        logic [3:0] cause;
    } fault_t;

    // Low address bits that must be zero for a given size.
    function automatic logic [1:0] low_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: low_mask = 2'b00;
            SZ_HALF: low_mask = 2'b01;
            default: low_mask = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/data_align_chk.sv
module data_align_chk
    import align_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            req_i,
    input  logic            we_i,
    input  acc_size_e       size_i,
    input  logic [XLEN-1:0] addr_i,
    output fault_t          flt_o
);
    logic [1:0] mask;
    logic       bad;

    always_comb begin
        mask = low_mask(size_i);
        bad  = req_i && ((addr_i[1:0] & mask) != 2'b00);
        flt_o.hit   = bad;
        flt_o.cause = bad ? (we_i ? CAUSE_STORE_MIS : CAUSE_LOAD_MIS) : 4'd0;
    end

    always_comb begin
        if (!$isunknown({req_i, size_i, addr_i[1:0]})) begin
            a_r7_byte_never: assert (!(req_i && size_i == SZ_BYTE) || !flt_o.hit);
            a_r11_idle_clean: assert (req_i || !flt_o.hit);
        end
    end
endmodule

// File: rtl/xfer_align_chk.sv
module xfer_align_chk
    import align_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int IALIGN_BITS = 2
) (
    input  logic            taken_i,
    input  logic [XLEN-1:0] target_i,
    output fault_t          flt_o
);
    generate
        if (IALIGN_BITS == 0) begin : g_any
            assign flt_o = '{hit: 1'b0, cause: 4'd0};
        end else begin : g_chk
            logic bad;
            assign bad   = taken_i && (target_i[IALIGN_BITS-1:0] != '0);
            assign flt_o = '{hit: bad, cause: CAUSE_XFER_MIS};
        end
    endgenerate

    always_comb begin
        if (!$isunknown(taken_i)) begin
            a_r2_not_taken_clean: assert (taken_i || !flt_o.hit);
        end
    end
endmodule

// File: rtl/align_arbiter.sv
module align_arbiter
    import align_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fault_t          xfer_i,
    input  logic [XLEN-1:0] xfer_addr_i,
    input  fault_t          data_i,
    input  logic [XLEN-1:0] data_addr_i,
    output fault_t          sel_o,
    output logic [XLEN-1:0] tval_o
);
    always_comb begin
        if (xfer_i.hit) begin
            sel_o  = xfer_i;
            tval_o = xfer_addr_i;
        end else if (data_i.hit) begin
            sel_o  = data_i;
            tval_o = data_addr_i;
        end else begin
            sel_o  = '{hit: 1'b0, cause: 4'd0};
            tval_o = '0;
        end
    end

    always_comb begin
        if (!$isunknown({xfer_i, data_i})) begin
            a_r10_xfer_wins: assert (!xfer_i.hit || sel_o.cause == CAUSE_XFER_MIS);
        end
    end
endmodule

// File: rtl/align_checker.sv
module align_checker
    import align_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            mem_req_i,
    input  logic            mem_we_i,
    input  logic [1:0]      mem_size_i,
    input  logic [XLEN-1:0] mem_addr_i,
    input  logic            xfer_taken_i,
    input  logic [XLEN-1:0] xfer_target_i,
    output logic            misalign_o,
    output logic [3:0]      cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic            mem_req_o,
    output logic            mem_we_o
);
    fault_t data_flt, xfer_flt, sel_flt;

    data_align_chk #(.XLEN(XLEN)) u_data (
        .req_i  (mem_req_i),
        .we_i   (mem_we_i),
        .size_i (acc_size_e'(mem_size_i)),
        .addr_i (mem_addr_i),
        .flt_o  (data_flt)
    );

    xfer_align_chk #(.XLEN(XLEN), .IALIGN_BITS(2)) u_xfer (
        .taken_i  (xfer_taken_i),
        .target_i (xfer_target_i),
        .flt_o    (xfer_flt)
    );

    align_arbiter #(.XLEN(XLEN)) u_arb (
        .xfer_i      (xfer_flt),
        .xfer_addr_i (xfer_target_i),
        .data_i      (data_flt),
        .data_addr_i (mem_addr_i),
        .sel_o       (sel_flt),
        .tval_o      (tval_o)
    );

    assign misalign_o = sel_flt.hit;
    assign cause_o    = sel_flt.cause;
    assign mem_req_o  = mem_req_i && !sel_flt.hit;
    assign mem_we_o   = mem_req_o && mem_we_i;

    always_comb begin
        if (!$isunknown({mem_req_i, mem_we_i, mem_size_i, mem_addr_i,
                         xfer_taken_i, xfer_target_i})) begin
            a_r9_no_write_on_fault: assert (!misalign_o || (!mem_we_o && !mem_req_o));
            a_r8_quiet_when_clean: assert (misalign_o || (tval_o == '0 && cause_o == 4'd0));
        end
    end
endmodule

// File: tb/align_checker_test.sv
module align_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            mem_req_i, mem_we_i, xfer_taken_i;
    logic [1:0]      mem_size_i;
    logic [XLEN-1:0] mem_addr_i, xfer_target_i;
    logic            misalign_o, mem_req_o, mem_we_o;
    logic [3:0]      cause_o;
    logic [XLEN-1:0] tval_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    align_checker #(.XLEN(XLEN)) uut (
        .mem_req_i, .mem_we_i, .mem_size_i, .mem_addr_i,
        .xfer_taken_i, .xfer_target_i,
        .misalign_o, .cause_o, .tval_o, .mem_req_o, .mem_we_o
    );

    task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (req=%b we=%b sz=%b addr=%h tk=%b tgt=%h)",
                     tag, act, exp, mem_req_i, mem_we_i, mem_size_i, mem_addr_i,
                     xfer_taken_i, xfer_target_i);
        end
    endtask

    initial begin
        mem_req_i = 0; mem_we_i = 0; mem_size_i = 0; mem_addr_i = 0;
        xfer_taken_i = 0; xfer_target_i = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R8 idle misalign", {31'd0, misalign_o}, 0);
        chk("R8 idle tval", tval_o, 0);
        chk("R9 idle req", {31'd0, mem_req_o}, 0);

        for (int req = 0; req < 2; req++)
        for (int we = 0; we < 2; we++)
        for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 8; lo++)
        for (int tk = 0; tk < 2; tk++)
        for (int tl = 0; tl < 4; tl++) begin
            logic [XLEN-1:0] a, t, e_tval;
            bit d_bad, x_bad, e_mis;
            int e_cause;
            string ctag;
            a = 32'hA5C3_F000 + 32'(lo) + 32'(req*16 + sz*64);
            t = 32'h0001_2340 + 32'(tl) + 32'(we*32);
            @(negedge clk);
            mem_req_i = req[0]; mem_we_i = we[0]; mem_size_i = sz[1:0];
            mem_addr_i = a; xfer_taken_i = tk[0]; xfer_target_i = t;
            #1;
            // expected, computed from the size rule
            case (sz)
                0: d_bad = 0;
                1: d_bad = (a % 2) != 0;
                default: d_bad = (a % 4) != 0;
            endcase
            d_bad = d_bad && (req == 1);
            x_bad = (tk == 1) && ((t % 4) != 0);
            e_mis = d_bad || x_bad;
            e_cause = x_bad ? 0 : (d_bad ? (we ? 6 : 4) : 0);
            e_tval = x_bad ? t : (d_bad ? a : 0);
            if (x_bad && d_bad) ctag = "R10";
            else if (x_bad) ctag = "R1";
            else if (tk == 1 && (t % 4) == 0) ctag = "R2";
            else if (req == 0) ctag = "R11";
            else if (sz == 0) ctag = "R7";
            else if (sz == 3) ctag = "R12";
            else if (sz == 2) ctag = we ? "R5" : "R3";
            else ctag = we ? "R6" : "R4";
            if (tk == 0 && (t % 4) != 0 && !d_bad) ctag = "R2";
            chk({ctag, " misalign"}, {31'd0, misalign_o}, {31'd0, e_mis});
            chk({ctag, " cause"}, {28'd0, cause_o}, 32'(e_cause));
            chk({ctag, " R8 tval"}, tval_o, e_tval);
            chk({ctag, " R9 req"}, {31'd0, mem_req_o}, {31'd0, (req == 1) && !e_mis});
            chk({ctag, " R9 we"}, {31'd0, mem_we_o}, {31'd0, (req == 1) && (we == 1) && !e_mis});
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule